// File: doc/BRIEF.md
# Program Counter and Control Sequencer

This block steps the program counter of a small 14-bit-instruction machine and controls the flow of execution around it. In each cycle it looks at the instruction word fetched from the current address. It uses a skip request and a bit-test value from the datapath. It produces the next 11-bit fetch address. Jumps, calls, the three return forms and taken skips each cost one extra cycle. The block marks that extra cycle with a flush output, and the instruction word seen during it is discarded. An eight-entry circular return stack holds the call return addresses.

The block also decodes a few control words that act outside the datapath. Return-with-literal raises a strobe for the datapath to load its working register with the literal. Return-from-interrupt raises a strobe that sets the global interrupt enable. Standby raises a strobe, updates two power status flags and stops execution until the wake input rises. Watchdog clear raises a strobe and sets both flags. The block does no arithmetic, holds no register file and has no timers.

Top module: `pc_sequencer`

## Requirements
- R1: While reset is low at a clock edge, the address goes to 0, the flush output goes low, and both status flags (time-out and power-down) go low. All strobes are low in the first cycle after reset.
- R2: An instruction that neither branches nor skips moves the address up by one on the next edge. The address wraps from 0x7FF to 0x000. The no-operation words 00 0000 0xx0 0000 cause nothing else.
- R3: A jump (bits 13:11 = 101) loads the address with bits 10:0 on the next edge and raises flush for that one cycle. In the flush cycle the instruction word is ignored and the address is held, so the target runs in the cycle after.
- R4: A call (bits 13:11 = 100) pushes its own address plus one and jumps like R3. A return (0x0008) pops that value into the address and raises flush for the next cycle.
- R5: Return-with-literal (bits 13:10 = 1101) raises the W-load strobe in its own cycle with the literal equal to bits 7:0, and it returns as in R4. No strobe is raised in a flush cycle.
- R6: Return-from-interrupt (0x0009) raises the interrupt-enable strobe in its own cycle and returns as in R4.
- R7: Bit-test-skip-if-clear (bits 13:10 = 0110) skips when the bit-test input is 0. Bit-test-skip-if-set (0111) skips when it is 1. A zero-skip (bits 13:8 = 001011 or 001111) skips when the skip request is 1. A taken skip adds one to the address, raises flush, and the flush cycle adds one more. A skip not taken acts as in R2.
- R8: The return stack holds 8 entries. A ninth nested call overwrites the oldest entry, and the next eight returns give the eight newest return addresses, newest first.
- R9: Standby (0x0063) raises the sleep strobe, sets power-down to 1 and time-out to 0, and advances the address by one. From then on the address is held and instructions are ignored until wake is high at an edge. The held address runs in the cycle after that edge.
- R10: Watchdog clear (0x0064) raises the watchdog strobe in its own cycle and sets both status flags to 1 on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr | input | 14 | Instruction word fetched from the current address |
| skip_req | input | 1 | Datapath result is zero (for zero-skip forms) |
| bit_val | input | 1 | Value of the tested register bit |
| wake | input | 1 | Ends standby |
| pc | output | 11 | Current fetch address |
| flush | output | 1 | Current cycle is a discarded no-operation |
| w_load | output | 1 | Load W with the literal |
| w_lit | output | 8 | Literal for W |
| gie_set | output | 1 | Set global interrupt enable |
| sleep_pulse | output | 1 | Standby entered |
| wdt_clr | output | 1 | Clear the watchdog timer |
| to_flag | output | 1 | Time-out status flag |
| pd_flag | output | 1 | Power-down status flag |

## Verification
The bench places a jump target at the top of the address range, so that a design that forgot to wrap, or that let the address run on during the jump's flush cycle, would land on the wrong word. It puts a standby and a return-with-literal inside flush cycles, where a design that decoded discarded words would send spurious strobes. It tries both skip polarities and both values of the skip request, which catches an inverted test or a skip that is always taken. It nests nine calls and unwinds eight, so a stack pointer that saturates or wraps the wrong way gives wrong return addresses.

// File: rtl/seq_pkg.sv
// Shared types and fixed encodings of the sequencer.
// Assumes a 14-bit instruction word with the opcode in the upper bits.
package seq_pkg;
    localparam int INSTR_W = 14;
    localparam int LIT_W   = 8;

    localparam logic [INSTR_W-1:0] ENC_RET     = 14'h0008;
    localparam logic [INSTR_W-1:0] ENC_RETI    = 14'h0009;
    localparam logic [INSTR_W-1:0] ENC_STANDBY = 14'h0063;
    localparam logic [INSTR_W-1:0] ENC_WDTCLR  = 14'h0064;

    typedef enum logic [3:0] {
        OP_PLAIN,
        OP_CALL,
        OP_JUMP,
        OP_RET,
        OP_RETI,
        OP_RETLIT,
        OP_SKIP_CLR,
        OP_SKIP_SET,
        OP_SKIP_ZERO,
        OP_STANDBY,
        OP_WDTCLR
    } op_e;
endpackage

// File: rtl/seq_decode.sv
// Sorts an instruction word into the classes the sequencer acts on.
// Assumes everything it does not recognise is datapath work (OP_PLAIN).
module seq_decode
    import seq_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output op_e                op
);
    // Classify the word; exact matches first, then opcode fields.
    always_comb begin
        op = OP_PLAIN;
        if (instr == ENC_RET)                   op = OP_RET;
        else if (instr == ENC_RETI)             op = OP_RETI;
        else if (instr == ENC_STANDBY)          op = OP_STANDBY;
        else if (instr == ENC_WDTCLR)           op = OP_WDTCLR;
        else if (instr[13:11] == 3'b100)        op = OP_CALL;
        else if (instr[13:11] == 3'b101)        op = OP_JUMP;
        else if (instr[13:10] == 4'b1101)       op = OP_RETLIT;
        else if (instr[13:10] == 4'b0110)       op = OP_SKIP_CLR;
        else if (instr[13:10] == 4'b0111)       op = OP_SKIP_SET;
        else if (instr[13:8] == 6'b001011 ||
                 instr[13:8] == 6'b001111)      op = OP_SKIP_ZERO;
    end
endmodule

// File: rtl/seq_ret_stack.sv
// Circular return-address stack. A push past DEPTH overwrites the oldest
// entry; a pop below empty wraps as well. Assumes push and pop never coincide.
module seq_ret_stack #(
    parameter int W     = 11,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] push_data,
    output logic [W-1:0] top
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] sp;

    // Pointer update: up on push, down on pop, wrapping at DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n)    sp <= '0;
        else if (push) sp <= (int'(sp) == DEPTH-1) ? '0 : sp + 1'b1;
        else if (pop)  sp <= (sp == '0) ? PW'(DEPTH-1) : sp - 1'b1;
    end

    // Entry write at the pointer on push.
    always_ff @(posedge clk) begin
        if (push) mem[sp] <= push_data;
    end

    // Most recent entry sits just below the pointer.
    always_comb top = mem[(sp == '0) ? PW'(DEPTH-1) : sp - 1'b1];

    // R8
    push_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> top == $past(push_data));
endmodule

// File: rtl/seq_power.sv
// Standby and status-flag state. Standby sets power-down, clears time-out
// and halts until wake; watchdog clear sets both flags.
// Assumes the strobes come only from executed (non-flushed) instructions.
module seq_power (
    input  logic clk,
    input  logic rst_n,
    input  logic do_standby,
    input  logic do_wdtclr,
    input  logic wake,
    output logic asleep,
    output logic to_flag,
    output logic pd_flag
);
    // Halt state: entered by standby, left on wake.
    always_ff @(posedge clk) begin
        if (!rst_n)      asleep <= 1'b0;
        else if (asleep) asleep <= !wake;
        else             asleep <= do_standby;
    end

    // Status flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            to_flag <= 1'b0;
            pd_flag <= 1'b0;
        end else if (do_standby) begin
            to_flag <= 1'b0;
            pd_flag <= 1'b1;
        end else if (do_wdtclr) begin
            to_flag <= 1'b1;
            pd_flag <= 1'b1;
        end
    end

    // R9
    sleep_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        do_standby |=> (pd_flag && !to_flag && asleep));
endmodule

// File: rtl/pc_sequencer.sv
// Program counter and control sequencer. Picks the next fetch address,
// turns the cycle after any branch or taken skip into a discarded slot,
// keeps the return stack and raises the control strobes.
// Assumes instr is the word at pc in the same cycle.
module pc_sequencer
    import seq_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int STACK_DEPTH = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INSTR_W-1:0] instr,
    input  logic               skip_req,
    input  logic               bit_val,
    input  logic               wake,
    output logic [ADDR_W-1:0]  pc,
    output logic               flush,
    output logic               w_load,
    output logic [LIT_W-1:0]   w_lit,
    output logic               gie_set,
    output logic               sleep_pulse,
    output logic               wdt_clr,
    output logic               to_flag,
    output logic               pd_flag
);
    op_e               op;
    logic [ADDR_W-1:0] pc_q, pc_d, pc_inc, stack_top;
    logic              flush_q, hold_q;
    logic              asleep, exec, is_pop, branch, skip;

    seq_decode u_dec (.instr(instr), .op(op));

    seq_ret_stack #(.W(ADDR_W), .DEPTH(STACK_DEPTH)) u_stack (
        .clk(clk), .rst_n(rst_n),
        .push(exec && op == OP_CALL), .pop(exec && is_pop),
        .push_data(pc_inc), .top(stack_top));

    seq_power u_pwr (
        .clk(clk), .rst_n(rst_n),
        .do_standby(sleep_pulse), .do_wdtclr(wdt_clr), .wake(wake),
        .asleep(asleep), .to_flag(to_flag), .pd_flag(pd_flag));

    // Execution qualifiers and branch / skip decisions.
    always_comb begin
        pc_inc = pc_q + 1'b1;
        exec   = !flush_q && !asleep;
        is_pop = (op == OP_RET) || (op == OP_RETI) || (op == OP_RETLIT);
        branch = exec && ((op == OP_CALL) || (op == OP_JUMP) || is_pop);
        skip   = exec && (((op == OP_SKIP_CLR)  && !bit_val) ||
                          ((op == OP_SKIP_SET)  &&  bit_val) ||
                          ((op == OP_SKIP_ZERO) &&  skip_req));
    end

    // Next address selection.
    always_comb begin
        if (asleep)                                  pc_d = pc_q;
        else if (flush_q)                            pc_d = hold_q ? pc_q : pc_inc;
        else if (op == OP_CALL || op == OP_JUMP)     pc_d = instr[ADDR_W-1:0];
        else if (is_pop)                             pc_d = stack_top;
        else                                         pc_d = pc_inc;
    end

    // Address and flush-slot registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q    <= '0;
            flush_q <= 1'b0;
            hold_q  <= 1'b0;
        end else begin
            pc_q    <= pc_d;
            flush_q <= branch || skip;
            hold_q  <= branch;
        end
    end

    // Output strobes, only for executed words.
    always_comb begin
        pc          = pc_q;
        flush       = flush_q;
        w_lit       = instr[LIT_W-1:0];
        w_load      = exec && (op == OP_RETLIT);
        gie_set     = exec && (op == OP_RETI);
        sleep_pulse = exec && (op == OP_STANDBY);
        wdt_clr     = exec && (op == OP_WDTCLR);
    end

    // R3
    jump_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && op == OP_JUMP) |=> (pc == $past(instr[ADDR_W-1:0]) && flush));
    // R3
    single_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !flush);
    // R9
    sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (asleep && !wake) |=> $stable(pc));
    // R5
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({w_load, gie_set, sleep_pulse, wdt_clr}));
    // R5
    flush_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !(w_load || gie_set || sleep_pulse || wdt_clr));
endmodule

// File: tb/tb_pc_sequencer.sv
module tb_pc_sequencer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] instr = '0;
    logic        skip_req = 1'b0, bit_val = 1'b0, wake = 1'b0;
    logic [10:0] pc;
    logic        flush, w_load, gie_set, sleep_pulse, wdt_clr, to_flag, pd_flag;
    logic [7:0]  w_lit;
    int checks = 0, errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    pc_sequencer dut (.clk(clk), .rst_n(rst_n), .instr(instr), .skip_req(skip_req),
        .bit_val(bit_val), .wake(wake), .pc(pc), .flush(flush), .w_load(w_load),
        .w_lit(w_lit), .gie_set(gie_set), .sleep_pulse(sleep_pulse),
        .wdt_clr(wdt_clr), .to_flag(to_flag), .pd_flag(pd_flag));

    localparam logic [13:0] RET = 14'h0008, RETI = 14'h0009,
                            STBY = 14'h0063, WCLR = 14'h0064, NOP = 14'h0000;

    function automatic logic [13:0] jmp(input logic [10:0] t); return {3'b101, t}; endfunction
    function automatic logic [13:0] call(input logic [10:0] t); return {3'b100, t}; endfunction
    function automatic logic [13:0] retlw(input logic [7:0] k); return {6'b110100, k}; endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [13:0] i, input logic s = 0, input logic b = 0,
                         input logic w = 0);
        instr = i; skip_req = s; bit_val = b; wake = w;
        #1;
    endtask

    task automatic adv;
        @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1 pc", pc, 0);
        chk("R1 flush", flush, 0);
        chk("R1 flags", {to_flag, pd_flag}, 0);
        chk("R1 strobes", {w_load, gie_set, sleep_pulse, wdt_clr}, 0);
    endtask

    task automatic t_seq;
        logic [10:0] p = pc;
        apply(NOP); adv; chk("R2 inc", pc, int'(11'(p + 1)));
        apply(14'h0060);
        chk("R2 nop quiet", {w_load, gie_set, sleep_pulse, wdt_clr}, 0);
        adv; chk("R2 inc2", pc, int'(11'(p + 2)));
        chk("R2 no flush", flush, 0);
    endtask

    task automatic t_jump;
        apply(jmp(11'h7FE)); adv;
        chk("R3 target", pc, 'h7FE);
        chk("R3 flush", flush, 1);
        apply(STBY);
        chk("R3 ignored in slot", sleep_pulse, 0);
        adv;
        chk("R3 held", pc, 'h7FE);
        chk("R3 flush end", flush, 0);
        chk("R3 no sleep", pd_flag, 0);
        apply(NOP); adv; chk("R2 top", pc, 'h7FF);
        apply(NOP); adv; chk("R2 wrap", pc, 0);
    endtask

    task automatic t_call;
        logic [10:0] p = pc;
        apply(call(11'h123)); adv;
        chk("R4 call target", pc, 'h123);
        chk("R4 call flush", flush, 1);
        apply(NOP); adv;
        apply(NOP); adv; chk("R4 body", pc, 'h124);
        apply(RET); adv;
        chk("R4 return", pc, int'(11'(p + 1)));
        chk("R4 return flush", flush, 1);
        apply(NOP); adv;
    endtask

    task automatic t_retlw;
        logic [10:0] p = pc;
        apply(call(11'h200)); adv; apply(NOP); adv;
        apply(retlw(8'hA5));
        chk("R5 w_load", w_load, 1);
        chk("R5 literal", w_lit, 'hA5);
        adv;
        chk("R5 return", pc, int'(11'(p + 1)));
        chk("R5 flush", flush, 1);
        apply(retlw(8'h3C));
        chk("R5 slot quiet", w_load, 0);
        adv;
    endtask

    task automatic t_reti;
        logic [10:0] p = pc;
        apply(call(11'h300)); adv; apply(NOP); adv;
        apply(RETI);
        chk("R6 gie", gie_set, 1);
        adv;
        chk("R6 return", pc, int'(11'(p + 1)));
        apply(NOP);
        chk("R6 gie off", gie_set, 0);
        adv;
    endtask

    task automatic skip_case(input string nm, input logic [13:0] i, input logic s,
                             input logic b, input bit taken);
        logic [10:0] p = pc;
        apply(i, s, b); adv;
        chk({"R7 pc ", nm}, pc, int'(11'(p + 1)));
        chk({"R7 flush ", nm}, flush, int'(taken));
        if (taken) begin
            apply(NOP); adv;
            chk({"R7 past ", nm}, pc, int'(11'(p + 2)));
        end
    endtask

    task automatic t_skip;
        skip_case("clr0", {4'b0110, 10'h005}, 0, 0, 1);
        skip_case("clr1", {4'b0110, 10'h005}, 0, 1, 0);
        skip_case("set1", {4'b0111, 10'h005}, 0, 1, 1);
        skip_case("set0", {4'b0111, 10'h005}, 0, 0, 0);
        skip_case("dz1",  {6'b001011, 8'h20}, 1, 0, 1);
        skip_case("dz0",  {6'b001011, 8'h20}, 0, 0, 0);
        skip_case("iz1",  {6'b001111, 8'h20}, 1, 0, 1);
    endtask

    task automatic t_overflow;
        logic [10:0] ret [9];
        for (int k = 0; k < 9; k++) begin
            ret[k] = pc + 1'b1;
            apply(call(11'((k + 1) * 16))); adv;
            apply(NOP); adv;
        end
        for (int k = 8; k >= 1; k--) begin
            apply(RET); adv;
            chk("R8 pop order", pc, int'(ret[k]));
            apply(NOP); adv;
        end
    endtask

    task automatic t_sleep;
        logic [10:0] p = pc;
        apply(STBY);
        chk("R9 strobe", sleep_pulse, 1);
        adv;
        chk("R9 flags", {to_flag, pd_flag}, 1);
        chk("R9 pc", pc, int'(11'(p + 1)));
        for (int k = 0; k < 3; k++) begin
            apply(jmp(11'h055));
            chk("R9 asleep quiet", sleep_pulse, 0);
            adv;
            chk("R9 held", pc, int'(11'(p + 1)));
        end
        apply(NOP, 0, 0, 1); adv;
        chk("R9 wake edge", pc, int'(11'(p + 1)));
        apply(NOP); adv;
        chk("R9 resumed", pc, int'(11'(p + 2)));
    endtask

    task automatic t_wdt;
        apply(WCLR);
        chk("R10 strobe", wdt_clr, 1);
        adv;
        chk("R10 flags", {to_flag, pd_flag}, 3);
        apply(NOP);
        chk("R10 strobe off", wdt_clr, 0);
        adv;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_seq(); t_jump(); t_call(); t_retlw(); t_reti();
        t_skip(); t_overflow(); t_sleep(); t_wdt();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule